// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block is the combinational decode-stage logic of a five-stage pipeline that settles conditional branches in decode rather than in execute. It splits the instruction held in the fetch/decode register into register numbers, an immediate and a jump index, and sign-extends the immediate. It checks the two compare operands for a read-after-write dependence on the instruction now in the memory stage. Where there is one, it takes that instruction's ALU result in place of the register-file data. It then compares the two operands for equality.

From the incoming next-PC it forms both the conditional-branch target and the absolute jump target. It also packs the decoded control signals into one nine-bit word. A stall select can replace that whole word with zeros, which turns the instruction into a bubble.

The operands, after any forwarding, go on to the decode/execute register and to the comparator. The taken flag uses the branch bit of the packed word, so a bubbled branch never redirects fetch. The register file, the opcode decoder and the stall decision itself sit outside this block.

Top module: `id_branch_resolver`

## Requirements
- R1: `src_rs` = `instr[25:21]`, `src_rt` = `instr[20:16]` and `dst_rd` = `instr[15:11]`.
- R2: `imm_ext` is `instr[15:0]` sign-extended to the data width, so bit 15 is copied into every upper bit.
- R3: `fwd_a` is 1 only when all four of these hold: `dec_branch` = 1, `exm_wr_en` = 1, `exm_dst` ≠ 0 and `exm_dst` = `src_rs`. `fwd_b` follows the same rule against `src_rt`. The two selects are decided independently, and both may be 1 at once.
- R4: `opnd_a` is `exm_alu_res` when `fwd_a` = 1 and `rf_rd_a` otherwise. `opnd_b` is `exm_alu_res` when `fwd_b` = 1 and `rf_rd_b` otherwise. These forwarded values are the operands handed on.
- R5: `ops_equal` is 1 exactly when `opnd_a` = `opnd_b`.
- R6: `br_taken` = `ctl_word[8]` AND `ops_equal`. It is therefore 0 whenever the word is bubbled.
- R7: `br_target` = `npc` + (`imm_ext` << 2), taken modulo 2^32.
- R8: `jmp_target` = {`npc[31:28]`, `instr[25:0]`, 2'b00}.
- R9: With `issue_en` = 1, `ctl_word` carries the decoded signals at these bits: 8 `dec_branch`, 7 `dec_reg_wr`, 6 `dec_mem2reg`, 5 `dec_mem_wr`, 4 `dec_mem_rd`, 3 `dec_dst_sel`, 2:1 `dec_alu_op`, 0 `dec_alu_src`.
- R10: With `issue_en` = 0, `ctl_word` is all zeros, whatever the decoded signals are.
- R11: A write to register 0 in the memory stage never forwards, even when the branch names register 0 as a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction in the fetch/decode register |
| npc | input | 32 | Next-PC in the fetch/decode register |
| rf_rd_a | input | 32 | Register-file data for rs |
| rf_rd_b | input | 32 | Register-file data for rt |
| exm_dst | input | 5 | Destination register of the memory-stage instruction |
| exm_wr_en | input | 1 | Memory-stage instruction writes a register |
| exm_alu_res | input | 32 | Memory-stage ALU result |
| dec_branch | input | 1 | Decoded conditional branch |
| dec_reg_wr | input | 1 | Decoded register write |
| dec_mem2reg | input | 1 | Decoded write-back from memory |
| dec_mem_wr | input | 1 | Decoded memory store |
| dec_mem_rd | input | 1 | Decoded memory load |
| dec_dst_sel | input | 1 | Decoded destination select (rd vs rt) |
| dec_alu_op | input | 2 | Decoded ALU operation class |
| dec_alu_src | input | 1 | Decoded ALU second-source select |
| issue_en | input | 1 | 1 passes the control word, 0 makes a bubble |
| src_rs | output | 5 | First source register number |
| src_rt | output | 5 | Second source register number |
| dst_rd | output | 5 | Destination register field |
| imm_ext | output | 32 | Sign-extended immediate |
| opnd_a | output | 32 | Forwarded first operand |
| opnd_b | output | 32 | Forwarded second operand |
| fwd_a | output | 1 | First operand taken from the memory stage |
| fwd_b | output | 1 | Second operand taken from the memory stage |
| ops_equal | output | 1 | Forwarded operands are equal |
| br_taken | output | 1 | Conditional branch is taken |
| br_target | output | 32 | Conditional-branch target |
| jmp_target | output | 32 | Absolute jump target |
| ctl_word | output | 9 | Packed control word, or zeros for a bubble |

## Verification
The bench builds the block with its default widths: 32-bit data, 5-bit register numbers and a 9-bit control word. These widths put the real corner cases within reach. The negative immediate tests that bit 15 is copied upward. The next-PC near the top of the address space tests that the target addition wraps, and an all-ones jump index tests the fixed top nibble. With register 0 as a source, the bench tests that a write to register 0 is not forwarded. It also covers both operands forwarding from the same writer, forwarding held off when the instruction is not a branch or the memory-stage instruction does not write, and a bubble that zeros the word even though the operands compare equal.

// File: rtl/br_pkg.sv
package br_pkg;

  localparam int XLEN  = 32;
  localparam int RNUM  = 5;
  localparam int IMMW  = 16;
  localparam int IDXW  = 26;
  localparam int CTLW  = 9;

  localparam int RS_LO = 21;
  localparam int RT_LO = 16;
  localparam int RD_LO = 11;

  // Bit positions inside the packed control word
  localparam int CB_BRANCH = 8;
  localparam int CB_REGWR  = 7;
  localparam int CB_M2R    = 6;
  localparam int CB_MEMWR  = 5;
  localparam int CB_MEMRD  = 4;
  localparam int CB_DSTSEL = 3;
  localparam int CB_ALUOP  = 1;
  localparam int CB_ALUSRC = 0;

  typedef logic [XLEN-1:0] word_t;
  typedef logic [RNUM-1:0] rnum_t;
  typedef logic [CTLW-1:0] ctl_t;

  function automatic word_t sext_imm(input logic [IMMW-1:0] imm);
    return word_t'({{(XLEN-IMMW){imm[IMMW-1]}}, imm});
  endfunction

  function automatic word_t branch_dest(input word_t base, input word_t ext);
    return base + (ext << 2);
  endfunction

  function automatic word_t jump_dest(input word_t base, input logic [IDXW-1:0] idx);
    return {base[XLEN-1 -: XLEN-IDXW-2], idx, 2'b00};
  endfunction

endpackage

// File: rtl/id_fwd_sel.sv
module id_fwd_sel
  import br_pkg::*;
(
  input  logic  is_branch,
  input  logic  wr_en,
  input  rnum_t wr_dst,
  input  rnum_t src,
  input  word_t rf_val,
  input  word_t byp_val,
  output logic  sel,
  output word_t val
);

  logic dst_live;
  logic hit;

  assign dst_live = wr_en && (wr_dst != '0);
  assign hit      = (wr_dst == src);
  assign sel      = is_branch && dst_live && hit;
  assign val      = sel ? byp_val : rf_val;

  always_comb begin
    if (sel) AST_FWD_NEEDS_WRITER: assert (wr_en && is_branch); // R3
    if (wr_dst == '0) AST_NO_FWD_R0: assert (!sel); // R11
    if (!sel) AST_RF_PASS: assert (val == rf_val); // R4
  end

endmodule

// File: rtl/id_targets.sv
module id_targets
  import br_pkg::*;
(
  input  word_t            npc,
  input  logic [IMMW-1:0]  imm,
  input  logic [IDXW-1:0]  idx,
  output word_t            ext,
  output word_t            br_dest,
  output word_t            jmp_dest
);

  assign ext      = sext_imm(imm);
  assign br_dest  = branch_dest(npc, ext);
  assign jmp_dest = jump_dest(npc, idx);

  always_comb begin
    AST_BR_WORD_OFFSET: assert (br_dest[1:0] == npc[1:0]); // R7
    if (imm[IMMW-1]) AST_SEXT_NEG: assert (&ext[XLEN-1:IMMW]); // R2
  end

endmodule

// File: rtl/id_ctl_pack.sv
module id_ctl_pack
  import br_pkg::*;
(
  input  logic       branch,
  input  logic       reg_wr,
  input  logic       mem2reg,
  input  logic       mem_wr,
  input  logic       mem_rd,
  input  logic       dst_sel,
  input  logic [1:0] alu_op,
  input  logic       alu_src,
  input  logic       pass,
  output ctl_t       word
);

  ctl_t packed_w;

  always_comb begin
    packed_w                       = '0;
    packed_w[CB_BRANCH]            = branch;
    packed_w[CB_REGWR]             = reg_wr;
    packed_w[CB_M2R]               = mem2reg;
    packed_w[CB_MEMWR]             = mem_wr;
    packed_w[CB_MEMRD]             = mem_rd;
    packed_w[CB_DSTSEL]            = dst_sel;
    packed_w[CB_ALUOP +: 2]        = alu_op;
    packed_w[CB_ALUSRC]            = alu_src;
  end

  assign word = pass ? packed_w : '0;

  always_comb begin
    if (!pass) AST_BUBBLE_ZERO: assert (word == '0); // R10
    if (word != '0) AST_WORD_NEEDS_PASS: assert (pass); // R9
  end

endmodule

// File: rtl/id_branch_resolver.sv
module id_branch_resolver
  import br_pkg::*;
#(
  parameter int DATA_W = br_pkg::XLEN,
  parameter int REG_W  = br_pkg::RNUM,
  parameter int CTL_W  = br_pkg::CTLW
) (
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] npc,
  input  logic [DATA_W-1:0] rf_rd_a,
  input  logic [DATA_W-1:0] rf_rd_b,
  input  logic [REG_W-1:0]  exm_dst,
  input  logic              exm_wr_en,
  input  logic [DATA_W-1:0] exm_alu_res,
  input  logic              dec_branch,
  input  logic              dec_reg_wr,
  input  logic              dec_mem2reg,
  input  logic              dec_mem_wr,
  input  logic              dec_mem_rd,
  input  logic              dec_dst_sel,
  input  logic [1:0]        dec_alu_op,
  input  logic              dec_alu_src,
  input  logic              issue_en,
  output logic [REG_W-1:0]  src_rs,
  output logic [REG_W-1:0]  src_rt,
  output logic [REG_W-1:0]  dst_rd,
  output logic [DATA_W-1:0] imm_ext,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              fwd_a,
  output logic              fwd_b,
  output logic              ops_equal,
  output logic              br_taken,
  output logic [DATA_W-1:0] br_target,
  output logic [DATA_W-1:0] jmp_target,
  output logic [CTL_W-1:0]  ctl_word
);

  localparam int NSRC = 2;

  rnum_t src_num [NSRC];
  word_t rf_val  [NSRC];
  word_t fwd_val [NSRC];
  logic  fwd_sel [NSRC];

  assign src_rs = instr[RS_LO +: REG_W];
  assign src_rt = instr[RT_LO +: REG_W];
  assign dst_rd = instr[RD_LO +: REG_W];

  assign src_num[0] = src_rs;
  assign src_num[1] = src_rt;
  assign rf_val[0]  = rf_rd_a;
  assign rf_val[1]  = rf_rd_b;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    id_fwd_sel u_fwd (
      .is_branch (dec_branch),
      .wr_en     (exm_wr_en),
      .wr_dst    (exm_dst),
      .src       (src_num[g]),
      .rf_val    (rf_val[g]),
      .byp_val   (exm_alu_res),
      .sel       (fwd_sel[g]),
      .val       (fwd_val[g])
    );
  end

  assign fwd_a     = fwd_sel[0];
  assign fwd_b     = fwd_sel[1];
  assign opnd_a    = fwd_val[0];
  assign opnd_b    = fwd_val[1];
  assign ops_equal = (opnd_a == opnd_b);

  id_targets u_tgt (
    .npc      (npc),
    .imm      (instr[IMMW-1:0]),
    .idx      (instr[IDXW-1:0]),
    .ext      (imm_ext),
    .br_dest  (br_target),
    .jmp_dest (jmp_target)
  );

  id_ctl_pack u_ctl (
    .branch  (dec_branch),
    .reg_wr  (dec_reg_wr),
    .mem2reg (dec_mem2reg),
    .mem_wr  (dec_mem_wr),
    .mem_rd  (dec_mem_rd),
    .dst_sel (dec_dst_sel),
    .alu_op  (dec_alu_op),
    .alu_src (dec_alu_src),
    .pass    (issue_en),
    .word    (ctl_word)
  );

  assign br_taken = ctl_word[CB_BRANCH] && ops_equal;

  always_comb begin
    if (br_taken) AST_TAKEN_NEEDS_MATCH: assert (opnd_a == opnd_b && dec_branch && issue_en); // R6
    if (fwd_a) AST_FWD_A_VALUE: assert (opnd_a == exm_alu_res); // R4
    if (fwd_b) AST_FWD_B_VALUE: assert (opnd_b == exm_alu_res); // R4
    if (fwd_a && fwd_b) AST_BOTH_FWD_EQUAL: assert (ops_equal); // R5
  end

endmodule

// File: tb/test_id_branch_resolver.sv
module test_id_branch_resolver;

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] npc;
    logic [31:0] rfa;
    logic [31:0] rfb;
    logic [31:0] alu;
    logic [4:0]  dst;
    logic        wr;
    logic [8:0]  ctl;
    logic        pass;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t TBL [NVEC] = '{
    // equal register data, plain taken branch
    '{32'h10640004, 32'h00400010, 32'd5, 32'd5, 32'd9, 5'd7, 1'b1, 9'h100, 1'b1},
    // rs forwarded, negative immediate
    '{32'h1064FFFC, 32'h00400020, 32'd1, 32'd5, 32'd5, 5'd3, 1'b1, 9'h100, 1'b1},
    // register 0 sources with a write to register 0
    '{32'h10000008, 32'h00400030, 32'd0, 32'd0, 32'd77, 5'd0, 1'b1, 9'h100, 1'b1},
    // not a branch: no forwarding despite a match
    '{32'h00643020, 32'h00400040, 32'd1, 32'd2, 32'd2, 5'd3, 1'b1, 9'h0AB, 1'b1},
    // bubbled branch with equal operands
    '{32'h10640004, 32'h00400050, 32'd8, 32'd8, 32'd0, 5'd9, 1'b0, 9'h1FF, 1'b0},
    // rt forwarded, not equal
    '{32'h10468000, 32'h00400060, 32'd4, 32'd4, 32'd6, 5'd6, 1'b1, 9'h100, 1'b1},
    // both sources the same register, both forwarded
    '{32'h11290010, 32'h00400070, 32'd1, 32'd2, 32'hDEAD, 5'd9, 1'b1, 9'h100, 1'b1},
    // jump with all-ones index and high next-PC
    '{32'h0BFFFFFF, 32'hF0000004, 32'd0, 32'd1, 32'd0, 5'd0, 1'b0, 9'h000, 1'b1},
    // match without register write: no forwarding
    '{32'h10640004, 32'h00400080, 32'd3, 32'd4, 32'd4, 5'd3, 1'b0, 9'h100, 1'b1}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] instr, npc, rf_rd_a, rf_rd_b, exm_alu_res;
  logic [4:0]  exm_dst;
  logic        exm_wr_en, issue_en;
  logic [8:0]  dctl;
  logic [4:0]  src_rs, src_rt, dst_rd;
  logic [31:0] imm_ext, opnd_a, opnd_b, br_target, jmp_target;
  logic        fwd_a, fwd_b, ops_equal, br_taken;
  logic [8:0]  ctl_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  id_branch_resolver i_id_branch_resolver (
    .instr       (instr),
    .npc         (npc),
    .rf_rd_a     (rf_rd_a),
    .rf_rd_b     (rf_rd_b),
    .exm_dst     (exm_dst),
    .exm_wr_en   (exm_wr_en),
    .exm_alu_res (exm_alu_res),
    .dec_branch  (dctl[8]),
    .dec_reg_wr  (dctl[7]),
    .dec_mem2reg (dctl[6]),
    .dec_mem_wr  (dctl[5]),
    .dec_mem_rd  (dctl[4]),
    .dec_dst_sel (dctl[3]),
    .dec_alu_op  (dctl[2:1]),
    .dec_alu_src (dctl[0]),
    .issue_en    (issue_en),
    .src_rs      (src_rs),
    .src_rt      (src_rt),
    .dst_rd      (dst_rd),
    .imm_ext     (imm_ext),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .fwd_a       (fwd_a),
    .fwd_b       (fwd_b),
    .ops_equal   (ops_equal),
    .br_taken    (br_taken),
    .br_target   (br_target),
    .jmp_target  (jmp_target),
    .ctl_word    (ctl_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    instr = v.instr; npc = v.npc; rf_rd_a = v.rfa; rf_rd_b = v.rfb;
    exm_alu_res = v.alu; exm_dst = v.dst; exm_wr_en = v.wr;
    dctl = v.ctl; issue_en = v.pass;
    #1;
  endtask

  task automatic check_all(input vec_t v);
    logic [4:0]  rs, rt;
    logic [31:0] ext, ea, eb;
    logic        fa, fb, eq;
    logic [8:0]  w;
    rs  = v.instr[25:21];
    rt  = v.instr[20:16];
    ext = v.instr[15] ? {16'hFFFF, v.instr[15:0]} : {16'h0000, v.instr[15:0]};
    fa  = v.ctl[8] && v.wr && (v.dst != 5'd0) && (v.dst == rs);
    fb  = v.ctl[8] && v.wr && (v.dst != 5'd0) && (v.dst == rt);
    ea  = fa ? v.alu : v.rfa;
    eb  = fb ? v.alu : v.rfb;
    eq  = (ea == eb);
    w   = v.pass ? v.ctl : 9'h000;
    chk("R1 rs", {27'd0, src_rs}, {27'd0, rs});
    chk("R1 rt", {27'd0, src_rt}, {27'd0, rt});
    chk("R1 rd", {27'd0, dst_rd}, {27'd0, v.instr[15:11]});
    chk("R2 imm", imm_ext, ext);
    chk("R3/R11 fwd_a", {31'd0, fwd_a}, {31'd0, fa});
    chk("R3/R11 fwd_b", {31'd0, fwd_b}, {31'd0, fb});
    chk("R4 opnd_a", opnd_a, ea);
    chk("R4 opnd_b", opnd_b, eb);
    chk("R5 equal", {31'd0, ops_equal}, {31'd0, eq});
    chk("R6 taken", {31'd0, br_taken}, {31'd0, w[8] & eq});
    chk("R7 br_target", br_target, v.npc + {ext[29:0], 2'b00});
    chk("R8 jmp_target", jmp_target, {v.npc[31:28], v.instr[25:0], 2'b00});
    chk("R9/R10 ctl_word", {23'd0, ctl_word}, {23'd0, w});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    vec_t v;
    // Idle state: everything zero, bubble selected
    v = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 5'd0, 1'b0, 9'h000, 1'b0};
    drive(v);
    chk("R10 idle ctl_word", {23'd0, ctl_word}, 32'd0);
    chk("R6 idle taken", {31'd0, br_taken}, 32'd0);
    check_all(v);

    for (int i = 0; i < NVEC; i++) begin
      drive(TBL[i]);
      check_all(TBL[i]);
    end

    // R7 target wraps past the top of the address space
    v = '{32'h10000001, 32'hFFFFFFFC, 32'd0, 32'd0, 32'd0, 5'd0, 1'b0, 9'h100, 1'b1};
    drive(v);
    chk("R7 wrap", br_target, 32'h00000000);
    check_all(v);

    // R9 each control bit lands in its own position
    for (int b = 0; b < 9; b++) begin
      v = '{32'h0, 32'h0, 32'd1, 32'd2, 32'd0, 5'd0, 1'b0, 9'(1 << b), 1'b1};
      drive(v);
      chk("R9 bit position", {23'd0, ctl_word}, 32'(1 << b));
    end

    // R10 bubble hides every decoded bit, R6 taken held off
    v = '{32'h10640004, 32'h0, 32'd5, 32'd5, 32'd0, 5'd0, 1'b0, 9'h1FF, 1'b0};
    drive(v);
    chk("R10 bubble all ones", {23'd0, ctl_word}, 32'd0);
    chk("R6 bubble taken", {31'd0, br_taken}, 32'd0);

    // R11 register-0 source, live write to register 0: no bypass
    v = '{32'h10000000, 32'h0, 32'd4, 32'd4, 32'd9, 5'd0, 1'b1, 9'h100, 1'b1};
    drive(v);
    chk("R11 opnd_a kept", opnd_a, 32'd4);
    chk("R11 taken", {31'd0, br_taken}, 32'd1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule